// File: doc/BRIEF.md
# SPI Slave Receiver with Held-Byte Double Buffering

This block is the receive side of an SPI slave fixed to mode 0. The serial clock, data and active-low select pins are brought into the system clock domain through a synchronizer. Rising serial-clock edges are detected there, and bits are shifted in most significant bit first. Each completed byte is handed to a one-byte receive buffer. The host takes bytes out of that buffer through a valid/ready stream port.

The buffer is never overwritten. If a byte completes while the buffer still holds an unaccepted byte, the new byte stays parked in the shift register. When the host next accepts, the parked byte moves into the buffer in the same cycle. If the master starts a third byte while one byte is parked, the parked byte is being destroyed. The block flags an overrun at the first sampled bit of that third byte and keeps receiving.

Recovery from an overrun takes two steps, done in either order:
- pulse the clear input, and
- accept two bytes.

The valid output and the overrun flag each drive a level interrupt request, and each request has its own enable.

Back-pressure rules for the stream port:
- `rx_valid` stays high and `rx_data` stays stable until the cycle in which `rx_ready` is also high.
- `rx_ready` may be held high permanently.
- The serial side is never stalled. When the host falls behind, the only effects are the parked byte and then the overrun flag.

Top module: `spi_rx_dbuf`

## Requirements
- R1: Bits are sampled on rising edges of `spi_sck` while `spi_cs_n` is low, most significant bit first; after 8 bits the byte appears on `rx_data` with `rx_valid` high.
- R2: A high level on `spi_cs_n` returns the bit counter to zero, so a partially received byte is discarded and the next byte starts from its first bit.
- R3: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` does not change.
- R4: A byte that completes while `rx_valid` is high is held in the shift register; `rx_data` keeps the older byte and no overrun is flagged.
- R5: An accept (`rx_valid` and `rx_ready` both high) with a byte held moves that byte to `rx_data` and keeps `rx_valid` high. An accept with no byte held drops `rx_valid`.
- R6: `ovr_flag` goes to 1 when the first bit of a new byte is sampled while a byte is held and no accept occurs in that cycle. It never rises unless `rx_valid` was high.
- R7: Reception continues after an overrun, and the buffered first byte is still delivered unchanged.
- R8: A one-cycle pulse on `ovr_clr` clears `ovr_flag`; without it the flag stays set. A clear pulse plus two accepts restore the idle state (`rx_valid` low, `ovr_flag` low) in either order.
- R9: `irq_rx` equals `rx_valid` AND `irq_rx_en`, and `irq_ovr` equals `ovr_flag` AND `irq_ovr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, asynchronous |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| rx_data | output | 8 | Buffered received byte |
| rx_valid | output | 1 | Buffer holds a byte (data-ready) |
| rx_ready | input | 1 | Host accepts the buffered byte when high with `rx_valid` |
| ovr_flag | output | 1 | Overrun flag |
| ovr_clr | input | 1 | Write-1 pulse that clears `ovr_flag` |
| irq_rx_en | input | 1 | Enable for the data-ready interrupt |
| irq_ovr_en | input | 1 | Enable for the overrun interrupt |
| irq_rx | output | 1 | Data-ready interrupt request, level |
| irq_ovr | output | 1 | Overrun interrupt request, level |

## Verification
The assertions check the following on every cycle:
- the stream port holds its byte and its valid while back-pressured;
- `rx_valid` falls only after an accept;
- the overrun flag stays set until a clear and rises only while a byte is buffered;
- each interrupt request never appears without its enable and its source.

Only the directed scenarios can show the following:
- the bit order;
- that a byte is parked in the shift register instead of overwriting the buffer;
- the exact moment the overrun fires, at the first bit of the third byte;
- that a select pulse discards partial bits;
- that both recovery orders return the block to idle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // Synchronized view of the three serial pins.
  typedef struct packed {
    logic sck;
    logic mosi;
    logic cs_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, cs_n: 1'b1};
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync
  import spi_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic mosi_s,
  output logic sel_s,
  output logic sck_rise
);
  spi_pins_t pipe_q [STAGES];
  logic      sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= PINS_IDLE;
      sck_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= '{sck: sck_i, mosi: mosi_i, cs_n: cs_n_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sck_prev_q <= pipe_q[STAGES-1].sck;
    end
  end

  assign mosi_s   = pipe_q[STAGES-1].mosi;
  assign sel_s    = ~pipe_q[STAGES-1].cs_n;
  assign sck_rise = pipe_q[STAGES-1].sck & ~sck_prev_q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output logic              first_bit,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_data,
  output logic [DATA_W-1:0] shift_q
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sreg_q;
  logic              take;

  assign take      = sel_s & sck_rise;
  assign byte_data = {sreg_q[DATA_W-2:0], mosi_s};
  assign byte_done = take & (cnt_q == LAST);
  assign first_bit = take & (cnt_q == '0);
  assign shift_q   = sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else if (!sel_s) begin
      cnt_q <= '0;
    end else if (take) begin
      sreg_q <= byte_data;
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_bit,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [DATA_W-1:0] shift_q,
  input  logic              rx_ready,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ovr_flag
);
  logic [DATA_W-1:0] buf_q;
  logic              valid_q, held_q, ovr_q, pop;

  assign pop = valid_q & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      valid_q <= 1'b0;
      held_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      // Buffer load: a held byte wins over a freshly completed one.
      if (pop && held_q)                       buf_q <= shift_q;
      else if (byte_done && (!valid_q || pop)) buf_q <= byte_data;

      if (pop) valid_q <= held_q | byte_done;
      else     valid_q <= valid_q | byte_done;

      if (held_q) held_q <= pop ? byte_done : 1'b1;
      else        held_q <= byte_done & valid_q & ~pop;

      if (first_bit && held_q && !pop) ovr_q <= 1'b1;
      else if (ovr_clr)                ovr_q <= 1'b0;
    end
  end

  assign rx_data  = buf_q;
  assign rx_valid = valid_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/spi_rx_dbuf.sv
module spi_rx_dbuf #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              ovr_flag,
  input  logic              ovr_clr,
  input  logic              irq_rx_en,
  input  logic              irq_ovr_en,
  output logic              irq_rx,
  output logic              irq_ovr
);
  logic              mosi_s, sel_s, sck_rise, first_bit, byte_done;
  logic [DATA_W-1:0] byte_data, shift_q;

  spi_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .mosi_i(spi_mosi), .cs_n_i(spi_cs_n),
    .mosi_s(mosi_s), .sel_s(sel_s), .sck_rise(sck_rise)
  );

  spi_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_rise(sck_rise), .mosi_s(mosi_s),
    .first_bit(first_bit), .byte_done(byte_done), .byte_data(byte_data), .shift_q(shift_q)
  );

  spi_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .first_bit(first_bit), .byte_done(byte_done),
    .byte_data(byte_data), .shift_q(shift_q), .rx_ready(rx_ready), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .ovr_flag(ovr_flag)
  );

  assign irq_rx  = rx_valid & irq_rx_en;
  assign irq_ovr = ovr_flag & irq_ovr_en;
endmodule

// File: rtl/spi_rx_dbuf_chk.sv
module spi_rx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              ovr_flag,
  input logic              ovr_clr,
  input logic              irq_rx_en,
  input logic              irq_ovr_en,
  input logic              irq_rx,
  input logic              irq_ovr
);
  // R3
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R5
  valid_falls_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_ready));

  // R6
  ovr_needs_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rx_valid));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clr |=> ovr_flag);

  // R9
  irq_rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_valid && irq_rx_en);

  // R9
  irq_ovr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> ovr_flag && irq_ovr_en);
endmodule

bind spi_rx_dbuf spi_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .irq_rx_en(irq_rx_en), .irq_ovr_en(irq_ovr_en),
  .irq_rx(irq_rx), .irq_ovr(irq_ovr)
);

// File: tb/spi_rx_dbuf_bench.sv
`timescale 1ns/1ps
module spi_rx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready = 1'b0, ovr_flag, ovr_clr = 1'b0;
  logic       irq_rx_en = 1'b0, irq_ovr_en = 1'b0, irq_rx, irq_ovr;
  int         checks = 0, failures = 0;

  always #10 clk = ~clk;

  spi_rx_dbuf u_spi_rx_dbuf (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .ovr_flag(ovr_flag),
    .ovr_clr(ovr_clr), .irq_rx_en(irq_rx_en), .irq_ovr_en(irq_ovr_en),
    .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    spi_mosi = b; wait_clk(4);
    spi_sck = 1'b1; wait_clk(8);
    spi_sck = 1'b0; wait_clk(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    wait_clk(6);
  endtask

  task automatic accept();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    wait_clk(1);
  endtask

  task automatic clear_ovr();
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_reset();
    check("R9 reset valid", rx_valid, 0);
    check("R6 reset ovr", ovr_flag, 0);
    check("R9 reset irq_rx", irq_rx, 0);
    check("R9 reset irq_ovr", irq_ovr, 0);
  endtask

  task automatic t_single();
    spi_cs_n = 1'b0; wait_clk(4);
    send_byte(8'hA5);
    check("R1 valid", rx_valid, 1);
    check("R1 data msb first", rx_data, 8'hA5);
    wait_clk(20);
    check("R3 still valid", rx_valid, 1);
    check("R3 data stable", rx_data, 8'hA5);
    accept();
    check("R5 accept empties", rx_valid, 0);
  endtask

  task automatic t_held();
    send_byte(8'h3C);
    send_byte(8'hC3);
    check("R4 older byte kept", rx_data, 8'h3C);
    check("R4 no overrun", ovr_flag, 0);
    accept();
    check("R5 held moves in", rx_data, 8'hC3);
    check("R5 valid stays", rx_valid, 1);
    accept();
    check("R5 second accept empties", rx_valid, 0);
  endtask

  task automatic t_overrun_clear_last();
    send_byte(8'h11);
    send_byte(8'h22);
    check("R6 no ovr before third", ovr_flag, 0);
    send_bit(1'b1);
    check("R6 ovr at first bit", ovr_flag, 1);
    for (int i = 6; i >= 0; i--) send_bit(i[0]);
    wait_clk(6);
    check("R7 first byte kept", rx_data, 8'h11);
    check("R7 valid", rx_valid, 1);
    irq_ovr_en = 1'b0; wait_clk(1);
    check("R9 irq_ovr gated off", irq_ovr, 0);
    irq_ovr_en = 1'b1; wait_clk(1);
    check("R9 irq_ovr on", irq_ovr, 1);
    accept();
    accept();
    check("R8 two accepts empty", rx_valid, 0);
    check("R8 ovr sticky without clear", ovr_flag, 1);
    clear_ovr();
    check("R8 ovr cleared", ovr_flag, 0);
    check("R9 irq_ovr drops", irq_ovr, 0);
    irq_ovr_en = 1'b0;
  endtask

  task automatic t_overrun_clear_first();
    send_byte(8'h44);
    send_byte(8'h55);
    send_byte(8'h66);
    check("R6 ovr after third byte", ovr_flag, 1);
    clear_ovr();
    check("R8 clear first", ovr_flag, 0);
    check("R7 buffer intact", rx_data, 8'h44);
    accept();
    check("R8 still valid after one accept", rx_valid, 1);
    accept();
    check("R8 idle after clear then two accepts", rx_valid, 0);
  endtask

  task automatic t_cs_reset();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    spi_cs_n = 1'b1; wait_clk(8);
    spi_cs_n = 1'b0; wait_clk(4);
    send_byte(8'h5A);
    check("R2 partial discarded", rx_data, 8'h5A);
    irq_rx_en = 1'b0; wait_clk(1);
    check("R9 irq_rx gated off", irq_rx, 0);
    irq_rx_en = 1'b1; wait_clk(1);
    check("R9 irq_rx on", irq_rx, 1);
    accept();
    check("R9 irq_rx drops", irq_rx, 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_single();
    t_held();
    t_overrun_clear_last();
    t_overrun_clear_first();
    t_cs_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule